// File: doc/BRIEF.md
# Framed SPI Slave Receiver

This block receives whole SPI messages as a slave in clock mode 0. The remote master pulls the active-low chip select low, clocks in bytes most significant bit first, and raises chip select to close the message. Each of the SCK, MOSI and chip-select inputs passes through a two-flop synchroniser clocked by the system clock. Edge detection and bit sampling then take place entirely in the system clock domain.

Each complete byte is written into a local buffer at the next free address. When chip select rises, the block presents the number of stored bytes and pulses a done strobe. Host logic arms the receiver before each message and reads the buffer through a combinational read port. Bytes that do not fit in the buffer are dropped and flagged. Messages that arrive while the receiver is not armed leave no trace.

Top module: `spi_frame_rx`

## Requirements
- R1: Each byte is assembled from MOSI as sampled on SCK rising edges. The first bit sampled becomes bit 7. The byte is stored at buffer address equal to its position in the message, counting from 0.
- R2: SCK and MOSI activity while chip select is high contributes no bits to any byte.
- R3: A rising chip select on an armed, receiving frame produces a done pulse exactly one clock wide. At that point count_o holds the number of complete bytes received, and it stays valid until the next arm.
- R4: Bits of an incomplete byte pending when chip select rises are discarded and are not counted.
- R5: When the message is longer than DEPTH bytes, the extra bytes are dropped and the first DEPTH buffer entries are kept. count_o stops at DEPTH, and overflow_o is high when done pulses.
- R6: A message that starts while the receiver is not armed is ignored. It produces no done pulse and leaves count_o and the buffer unchanged. After a done pulse the receiver is no longer armed.
- R7: A one-cycle arm_i pulse clears count_o and overflow_o at the next clock edge. Reception then waits for the next falling edge of chip select, so a frame already in progress at arm time is ignored.
- R8: After chip select rises between two clock edges, done_o is low following the first and second edges and high following the third (two synchroniser stages plus one control register).
- R9: A byte whose eighth SCK rise lands one clock before the chip select rise is counted and stored, in the same cycle that the frame closes.
- R10: After reset the receiver is disarmed, with done_o low, count_o zero and overflow_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | One-cycle pulse arming reception of the next message |
| sck_i | input | 1 | SPI serial clock from the master (asynchronous) |
| mosi_i | input | 1 | SPI data from the master (asynchronous) |
| csn_i | input | 1 | Active-low chip select framing a message (asynchronous) |
| rd_addr_i | input | $clog2(DEPTH) | Buffer read address |
| rd_data_o | output | WORD | Buffer byte at rd_addr_i (combinational) |
| done_o | output | 1 | One-cycle strobe at message end |
| count_o | output | $clog2(DEPTH+1) | Number of bytes stored in the last message |
| overflow_o | output | 1 | Set when a byte of the current message was dropped |

## Verification
Two events can fall in the same cycle: the commit of the last byte and the close of the frame. The commit is the registered byte-valid one cycle after the eighth synchronised SCK rise. The close is the synchronised chip-select rise. The bench provokes this by raising chip select one system clock after the final SCK rise. It then expects the done strobe to report a count that already includes that byte, and expects the byte to be present in the buffer. A raw chip-select rise that lands together with an SCK rise shows the opposite ordering: that bit arrives with chip select already high and is not sampled.

// File: rtl/spi_frame_rx_pkg.sv
package spi_frame_rx_pkg;

  typedef enum logic [1:0] {
    RX_OFF  = 2'd0,
    RX_WAIT = 2'd1,
    RX_RECV = 2'd2
  } rx_state_e;

  // True while the buffer still has a free slot.
  function automatic logic has_room(input int unsigned fill, input int unsigned cap);
    return fill < cap;
  endfunction

  // True when the bit about to be sampled completes a word.
  function automatic logic last_bit(input int unsigned idx, input int unsigned width);
    return idx == width - 1;
  endfunction

  function automatic logic edge_up(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  function automatic logic edge_down(input logic cur, input logic prev);
    return ~cur & prev;
  endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned N       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] sync_o
);

  logic [N-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= RST_VAL;
        end else begin
          if (g == 0) stage_q[g] <= raw_i;
          else        stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/spi_shift.sv
module spi_shift
  import spi_frame_rx_pkg::*;
#(
  parameter int unsigned WORD = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sck_rise_i,
  input  logic            mosi_i,
  input  logic            csn_i,
  output logic            byte_vld_o,
  output logic [WORD-1:0] byte_o
);

  localparam int unsigned BW = $clog2(WORD);

  logic [BW-1:0]   bit_q;
  logic [WORD-2:0] shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q      <= '0;
      shreg_q    <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      byte_vld_o <= 1'b0;
      if (csn_i) begin
        bit_q <= '0;
      end else if (sck_rise_i) begin
        shreg_q <= {shreg_q[WORD-3:0], mosi_i};
        if (last_bit(32'(bit_q), WORD)) begin
          bit_q      <= '0;
          byte_vld_o <= 1'b1;
          byte_o     <= {shreg_q, mosi_i};
        end else begin
          bit_q <= bit_q + BW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl
  import spi_frame_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          csn_fall_i,
  input  logic          csn_rise_i,
  input  logic          byte_vld_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [CW-1:0] count_o,
  output logic          overflow_o,
  output logic          done_o,
  output logic          armed_o
);

  rx_state_e     state_q;
  logic [CW-1:0] count_q;
  logic          room;

  assign room      = has_room(32'(count_q), DEPTH);
  assign wr_en_o   = (state_q == RX_RECV) && byte_vld_i && room && !arm_i;
  assign wr_addr_o = count_q[AW-1:0];
  assign count_o   = count_q;
  assign armed_o   = (state_q != RX_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= RX_OFF;
      count_q    <= '0;
      overflow_o <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (arm_i) begin
        state_q    <= RX_WAIT;
        count_q    <= '0;
        overflow_o <= 1'b0;
      end else begin
        case (state_q)
          RX_WAIT: if (csn_fall_i) state_q <= RX_RECV;
          RX_RECV: begin
            // a byte committing in the closing cycle is still counted
            if (byte_vld_i) begin
              if (room) count_q    <= count_q + CW'(1);
              else      overflow_o <= 1'b1;
            end
            if (csn_rise_i) begin
              state_q <= RX_OFF;
              done_o  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_frame_buf.sv
module spi_frame_buf #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WORD  = 8,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [WORD-1:0] wdata_i,
  input  logic [AW-1:0]   raddr_i,
  output logic [WORD-1:0] rdata_o
);

  logic [WORD-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_frame_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WORD  = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm_i,
  input  logic            sck_i,
  input  logic            mosi_i,
  input  logic            csn_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [WORD-1:0] rd_data_o,
  output logic            done_o,
  output logic [CW-1:0]   count_o,
  output logic            overflow_o
);

  // bit order of the synchroniser vector
  localparam int unsigned IDX_SCK  = 0;
  localparam int unsigned IDX_MOSI = 1;
  localparam int unsigned IDX_CSN  = 2;

  logic [2:0]      pins_s;
  logic            sck_s, mosi_s, csn_s;
  logic            sck_prev, csn_prev;
  logic            sck_rise, csn_rise, csn_fall;
  logic            byte_vld;
  logic [WORD-1:0] byte_data;
  logic            wr_en;
  logic [AW-1:0]   wr_addr;
  logic            armed;

  spi_in_sync #(.N(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({csn_i, mosi_i, sck_i}),
    .sync_o (pins_s)
  );

  assign sck_s  = pins_s[IDX_SCK];
  assign mosi_s = pins_s[IDX_MOSI];
  assign csn_s  = pins_s[IDX_CSN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      csn_prev <= 1'b1;
    end else begin
      sck_prev <= sck_s;
      csn_prev <= csn_s;
    end
  end

  assign sck_rise = edge_up(sck_s, sck_prev);
  assign csn_rise = edge_up(csn_s, csn_prev);
  assign csn_fall = edge_down(csn_s, csn_prev);

  spi_shift #(.WORD(WORD)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_rise_i (sck_rise),
    .mosi_i     (mosi_s),
    .csn_i      (csn_s),
    .byte_vld_o (byte_vld),
    .byte_o     (byte_data)
  );

  spi_frame_ctl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (arm_i),
    .csn_fall_i (csn_fall),
    .csn_rise_i (csn_rise),
    .byte_vld_i (byte_vld),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .count_o    (count_o),
    .overflow_o (overflow_o),
    .done_o     (done_o),
    .armed_o    (armed)
  );

  spi_frame_buf #(.DEPTH(DEPTH), .WORD(WORD), .AW(AW)) u_buf (
    .clk     (clk),
    .we_i    (wr_en),
    .waddr_i (wr_addr),
    .wdata_i (byte_data),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

endmodule

// File: rtl/spi_frame_rx_chk.sv
module spi_frame_rx_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm_i,
  input logic          done_o,
  input logic [CW-1:0] count_o,
  input logic          overflow_o,
  input logic          csn_s,
  input logic          csn_rise,
  input logic          byte_vld,
  input logic          armed
);

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((count_o != $past(count_o)) && !$past(arm_i)) |-> (count_o == $past(count_o) + CW'(1)));

  assert_frame_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> !$past(csn_s));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_on_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(csn_rise));

  assert_count_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CW'(DEPTH));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow_o) |-> ($past(byte_vld) && ($past(count_o) == CW'(DEPTH))));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !arm_i) |=> ($stable(count_o) && !done_o));

  assert_arm_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> ((count_o == '0) && !overflow_o && !done_o));

endmodule

bind spi_frame_rx spi_frame_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .arm_i      (arm_i),
  .done_o     (done_o),
  .count_o    (count_o),
  .overflow_o (overflow_o),
  .csn_s      (csn_s),
  .csn_rise   (csn_rise),
  .byte_vld   (byte_vld),
  .armed      (armed)
);

// File: tb/spi_frame_rx_tb.sv
`timescale 1ns/1ps
module spi_frame_rx_tb;

  localparam int DEPTH = 16;
  localparam int WORD  = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            arm_i = 1'b0;
  logic            sck_i = 1'b0;
  logic            mosi_i = 1'b0;
  logic            csn_i = 1'b1;
  logic [AW-1:0]   rd_addr_i = '0;
  logic [WORD-1:0] rd_data_o;
  logic            done_o;
  logic [CW-1:0]   count_o;
  logic            overflow_o;

  always #2 clk = ~clk;

  spi_frame_rx #(.DEPTH(DEPTH), .WORD(WORD)) u_dut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .sck_i(sck_i), .mosi_i(mosi_i),
    .csn_i(csn_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .done_o(done_o), .count_o(count_o), .overflow_o(overflow_o)
  );

  typedef struct { int cnt; bit ovf; } exp_t;
  exp_t expq[$];
  exp_t e;
  int   checks = 0;
  int   errors = 0;
  int   dones_seen = 0;
  bit   done_was = 1'b0;
  bit   finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 37 + 5);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (done_was) check(done_o == 1'b0, "R3 done width", int'(done_o), 0);
    if (rst_n && done_o) begin
      dones_seen++;
      if (expq.size() == 0) begin
        check(1'b0, "R6 unexpected done", 1, 0);
      end else begin
        e = expq.pop_front();
        check(int'(count_o) == e.cnt, "R3 count", int'(count_o), e.cnt);
        check(overflow_o == e.ovf, "R5 overflow", int'(overflow_o), int'(e.ovf));
      end
    end
    done_was = rst_n && done_o;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    mosi_i = b; sck_i = 1'b0; tick(2);
    sck_i = 1'b1; tick(2);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic open_frame();
    csn_i = 1'b0; tick(4);
  endtask

  task automatic close_frame();
    sck_i = 1'b0; tick(3);
    csn_i = 1'b1; tick(8);
  endtask

  task automatic do_arm();
    arm_i = 1'b1; tick(1);
    arm_i = 1'b0; tick(2);
  endtask

  task automatic push_exp(input int c, input bit o);
    exp_t x;
    x.cnt = c; x.ovf = o;
    expq.push_back(x);
  endtask

  task automatic buf_chk(input int idx, input logic [7:0] exp, input string req);
    rd_addr_i = AW'(idx); #1;
    check(rd_data_o == exp, req, int'(rd_data_o), int'(exp));
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(2);
    // R10 reset state
    check(done_o == 1'b0, "R10 done", int'(done_o), 0);
    check(count_o == '0, "R10 count", int'(count_o), 0);
    check(overflow_o == 1'b0, "R10 overflow", int'(overflow_o), 0);

    // R6 message before any arm is ignored
    open_frame(); send_byte(8'h11); send_byte(8'h22); close_frame();
    check(dones_seen == 0, "R6 no done unarmed", dones_seen, 0);
    check(count_o == '0, "R6 count unarmed", int'(count_o), 0);

    // R1 basic message, MSB first, stored in order
    do_arm();
    open_frame();
    send_byte(8'hA5); send_byte(8'h3C); send_byte(8'hFF); send_byte(8'h00);
    push_exp(4, 1'b0);
    close_frame();
    check(dones_seen == 1, "R3 one done", dones_seen, 1);
    buf_chk(0, 8'hA5, "R1 byte0");
    buf_chk(1, 8'h3C, "R1 byte1");
    buf_chk(2, 8'hFF, "R1 byte2");
    buf_chk(3, 8'h00, "R1 byte3");
    check(count_o == CW'(4), "R3 count held", int'(count_o), 4);

    // R2 SCK/MOSI toggling with chip select high adds no bits
    do_arm();
    for (int i = 0; i < 11; i++) send_bit(i[0]);
    sck_i = 1'b0; tick(3);
    open_frame(); send_byte(8'h81);
    push_exp(1, 1'b0);
    close_frame();
    buf_chk(0, 8'h81, "R2 byte after idle clocks");

    // R4 partial trailing byte dropped
    do_arm();
    open_frame();
    send_byte(8'hB4); send_byte(8'h2D);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    push_exp(2, 1'b0);
    close_frame();
    buf_chk(1, 8'h2D, "R4 last full byte");

    // R5 overflow
    do_arm();
    open_frame();
    for (int i = 0; i < DEPTH + 3; i++) send_byte(pat(i));
    push_exp(DEPTH, 1'b1);
    close_frame();
    for (int i = 0; i < DEPTH; i++) buf_chk(i, pat(i), "R5 kept entries");
    check(overflow_o == 1'b1, "R5 overflow held", int'(overflow_o), 1);

    // R6 no re-arm after done: message lost
    open_frame(); send_byte(8'hEE); send_byte(8'hDD); close_frame();
    check(dones_seen == 4, "R6 no done without re-arm", dones_seen, 4);
    check(count_o == CW'(DEPTH), "R6 count kept", int'(count_o), DEPTH);
    buf_chk(0, pat(0), "R6 buffer untouched");

    // R7 arm clears count and overflow at the next edge
    arm_i = 1'b1; tick(1);
    check(count_o == '0, "R7 count cleared", int'(count_o), 0);
    check(overflow_o == 1'b0, "R7 overflow cleared", int'(overflow_o), 0);
    arm_i = 1'b0; tick(2);

    // R7 arm during a frame in progress: that frame is ignored
    csn_i = 1'b0; tick(4);
    do_arm();
    send_byte(8'h77);
    close_frame();
    check(dones_seen == 4, "R7 mid-frame ignored", dones_seen, 4);
    check(count_o == '0, "R7 mid-frame count", int'(count_o), 0);
    open_frame(); send_byte(8'h42);
    push_exp(1, 1'b0);
    close_frame();
    buf_chk(0, 8'h42, "R7 next frame received");

    // R9 last byte commit in the closing cycle
    do_arm();
    open_frame();
    send_byte(8'h10); send_byte(8'h20);
    for (int i = 7; i >= 1; i--) send_bit(i == 5 || i == 4);
    mosi_i = 1'b0; sck_i = 1'b0; tick(2);
    push_exp(3, 1'b0);
    sck_i = 1'b1; tick(1);
    csn_i = 1'b1; tick(2);
    sck_i = 1'b0; tick(8);
    buf_chk(2, 8'h30, "R9 coincident byte stored");

    // R8 close-to-done latency
    do_arm();
    open_frame(); send_byte(8'h5A);
    sck_i = 1'b0; tick(3);
    push_exp(1, 1'b0);
    csn_i = 1'b1;
    tick(1); check(done_o == 1'b0, "R8 edge1", int'(done_o), 0);
    tick(1); check(done_o == 1'b0, "R8 edge2", int'(done_o), 0);
    tick(1); check(done_o == 1'b1, "R8 edge3", int'(done_o), 1);
    tick(8);

    check(expq.size() == 0, "R3 all expected dones seen", expq.size(), 0);
    check(dones_seen == 7, "R3 done total", dones_seen, 7);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule